// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two W-bit numbers one bit position per clock, lowest bit first, with a single full adder instead of a W-bit carry chain. Two operand registers are filled in parallel by a load strobe and then shift right together. At each shift the full adder combines the low bit of each operand with a stored carry. The sum bit enters the top of the first operand register, and the new carry goes back into the carry flip-flop. After W shifts the first operand register holds the W-bit sum and the carry flip-flop holds the carry out of the top position.

The second operand register takes its top bit from an external serial pin during shifts. A caller can therefore stream in the next addend while the current one is being consumed, or tie the pin to the register's own low bit (seen from outside as the streamed pattern) to keep the addend. A start that is not preceded by a load adds the current second operand and the held carry to the previous sum, so several additions can be chained.

Top module: `serial_adder`

## Requirements
- R1: After reset, `sum_o` is 0, `cout_o` is 0, and `busy_o` and `done_o` are both low.
- R2: A cycle with `ld_i` high copies `a_par_i` into the result register and `b_par_i` into the addend register, and clears the carry. From the next cycle `sum_o` equals the loaded `a_par_i`, `cout_o` is 0, and `busy_o` and `done_o` are low. A load during an addition abandons it and produces no `done_o`.
- R3: When `ld_i` and `go_i` are high in the same cycle, the load takes effect and no addition starts.
- R4: `go_i` sampled high while idle and without a load raises `busy_o` on the next cycle. Exactly W shift cycles follow. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R5: Every shift cycle moves the result register right by one place, with the new sum bit entering bit W-1. When `done_o` is high, `sum_o` is (A + B + carry_in) mod 2^W and `cout_o` is bit W of that total.
- R6: Every shift cycle also moves the addend register right, with `b_ser_i` entering bit W-1. After a full addition, the addend holds the W values presented on `b_ser_i`: the value presented for shift k (k = 0 first) sits at bit k.
- R7: `go_i` while `busy_o` is high has no effect: the addition still ends after exactly W shifts with the same result.
- R8: The carry is cleared only by reset or load. A start without a preceding load uses the carry left by the previous addition as its carry-in.
- R9: While `busy_o` is low and `ld_i` is low, `sum_o` and `cout_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_i | input | 1 | Parallel load of both operands; clears the carry |
| a_par_i | input | W | First operand, parallel value |
| b_par_i | input | W | Second operand, parallel value |
| go_i | input | 1 | Start an addition of W shift cycles |
| b_ser_i | input | 1 | Bit entering the top of the addend register on each shift |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle pulse after the last shift |
| sum_o | output | W | Result register contents |
| cout_o | output | 1 | Carry flip-flop contents |

## Verification
The assertions assume that reset is held for at least one clock before they start checking, and that `ld_i` and `go_i` are never X once reset has been released. Given that, every load, start and serial input pattern is legal, including a load in mid-addition. The stimulus drives all inputs on the falling edge. It raises `go_i` only at the start of an addition, or on purpose during one to exercise R7, and it holds `b_ser_i` at a defined value on every shift cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // Operation applied to an operand register in one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

    // One bit position of addition
    typedef struct packed {
        logic s;
        logic c;
    } fa_t;

    function automatic fa_t fa_eval(input logic x, input logic y, input logic ci);
        fa_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/sa_opreg.sv
module sa_opreg
    import sa_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] q_o,
    output logic         lsb_o
);

    logic [W-1:0] q;
    logic [W-1:0] q_next;

    // Each cell chooses among hold, parallel load and its upper neighbour
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic upper;
        if (i == W - 1) begin : g_top
            assign upper = ser_i;
        end else begin : g_mid
            assign upper = q[i+1];
        end

        always_comb begin
            unique case (op)
                OP_LOAD:  q_next[i] = par_i[i];
                OP_SHIFT: q_next[i] = upper;
                default:  q_next[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    assign q_o   = q;
    assign lsb_o = q[0];

endmodule

// File: rtl/sa_bitadd.sv
module sa_bitadd
    import sa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_q
);

    fa_t  fa;
    logic carry;

    assign fa = fa_eval(a_bit, b_bit, carry);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            carry <= 1'b0;
        end else if (step) begin
            carry <= fa.c;
        end
    end

    assign sum_bit = fa.s;
    assign carry_q = carry;

endmodule

// File: rtl/sa_seq.sv
module sa_seq
    import sa_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic go,
    output op_e  op,
    output logic busy,
    output logic done
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic          busy_q;
    logic          done_q;

    always_comb begin
        if (ld) begin
            op = OP_LOAD;
        end else if (busy_q) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (ld) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                if (cnt == LAST) begin
                    cnt    <= '0;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (go) begin
                cnt    <= '0;
                busy_q <= 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import sa_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] a_par_i,
    input  logic [W-1:0] b_par_i,
    input  logic         go_i,
    input  logic         b_ser_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    op_e          op;
    logic         a_lsb;
    logic         b_lsb;
    logic         sum_bit;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    sa_seq #(.W(W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .ld   (ld_i),
        .go   (go_i),
        .op   (op),
        .busy (busy_o),
        .done (done_o)
    );

    // Result register: sum bits re-enter at the top
    sa_opreg #(.W(W)) u_areg (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .par_i (a_par_i),
        .ser_i (sum_bit),
        .q_o   (a_q),
        .lsb_o (a_lsb)
    );

    // Addend register: fed from the serial pin
    sa_opreg #(.W(W)) u_breg (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .par_i (b_par_i),
        .ser_i (b_ser_i),
        .q_o   (b_q),
        .lsb_o (b_lsb)
    );

    sa_bitadd u_add (
        .clk     (clk),
        .rst     (rst),
        .clr     (ld_i),
        .step    (op == OP_SHIFT),
        .a_bit   (a_lsb),
        .b_bit   (b_lsb),
        .sum_bit (sum_bit),
        .carry_q (cout_o)
    );

    assign sum_o = a_q;

endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         ld_i,
    input logic         go_i,
    input logic [W-1:0] a_par_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] sum_o,
    input logic         cout_o
);

    localparam int RW = $clog2(W + 2) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> (sum_o == $past(a_par_i)) && !cout_o && !busy_o && !done_o);

    p_ld_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_i && go_i) |=> !busy_o);

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && go_i && !ld_i) |=> busy_o);

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_window_r4: assert property (@(posedge clk) disable iff (rst)
        run_len <= RW'(W));

    p_full_run_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ld_i && (run_len == RW'(W - 1))) |=> (done_o && !busy_o));

    p_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ld_i) |=> (sum_o[W-2:0] == $past(sum_o[W-1:1])));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ld_i) |=> ($stable(sum_o) && $stable(cout_o)));

endmodule

bind serial_adder sa_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ld_i    (ld_i),
    .go_i    (go_i),
    .a_par_i (a_par_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
);

// File: tb/tb_serial_adder.sv
module tb_serial_adder;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_i = 1'b0;
    logic [W-1:0] a_par_i = '0;
    logic [W-1:0] b_par_i = '0;
    logic         go_i = 1'b0;
    logic         b_ser_i = 1'b0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the operand state
    logic [W-1:0] ma;
    logic [W-1:0] mb;
    logic         mc;

    always #5 clk = ~clk;

    serial_adder #(.W(W)) dut (
        .clk(clk), .rst(rst), .ld_i(ld_i), .a_par_i(a_par_i), .b_par_i(b_par_i),
        .go_i(go_i), .b_ser_i(b_ser_i), .busy_o(busy_o), .done_o(done_o),
        .sum_o(sum_o), .cout_o(cout_o)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic ci);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        ld_i = 1'b1; a_par_i = a; b_par_i = b;
        @(negedge clk);
        ld_i = 1'b0;
        ma = a; mb = b; mc = 1'b0;
        chk(sum_o == a && cout_o == 1'b0 && !busy_o, "R2 load", {cout_o, sum_o}, a);
    endtask

    // runs a full addition, streaming bits into the addend register
    task automatic do_run(input logic [W-1:0] bits, input bit poke_go, input string tag);
        logic [W:0] exp;
        exp = ref_add(ma, mb, mc);
        @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        chk(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
        for (int i = 0; i < W; i++) begin
            b_ser_i = bits[i];
            if (poke_go && i == 1) go_i = 1'b1;
            if (i == 2) go_i = 1'b0;
            if (i > 0) chk(done_o == 1'b0, "R4 no early done", done_o, 0);
            @(negedge clk);
        end
        chk(done_o && !busy_o, "R4 done after W shifts", {busy_o, done_o}, 1);
        chk({cout_o, sum_o} == exp, tag, {cout_o, sum_o}, exp);
        @(negedge clk);
        chk(done_o == 1'b0 && !busy_o, "R4 done one cycle", {busy_o, done_o}, 0);
        chk({cout_o, sum_o} == exp, "R9 idle hold", {cout_o, sum_o}, exp);
        ma = exp[W-1:0]; mc = exp[W]; mb = bits;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        join_none

        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sum_o == 0 && cout_o == 0 && !busy_o && !done_o, "R1 reset",
            {busy_o, done_o, cout_o, sum_o}, 0);

        // directed corners
        do_load(4'hF, 4'h1);
        do_run(4'h0, 1'b0, "R5 carry ripples full width");
        do_load(4'h0, 4'h0);
        do_run(4'h0, 1'b0, "R5 zero plus zero");
        do_load(4'hF, 4'hF);
        do_run(4'h3, 1'b0, "R5 max plus max");
        // addend now equals streamed bits 4'h3; carry-in is held carry 1
        do_run(4'h0, 1'b0, "R6 R8 chained add uses streamed addend and held carry");
        do_load(4'h5, 4'h6);
        do_run(4'h9, 1'b1, "R7 start during add ignored");
        do_run(4'h0, 1'b0, "R6 streamed addend 4'h9");

        // R3 load and start together
        @(negedge clk);
        ld_i = 1'b1; go_i = 1'b1; a_par_i = 4'hA; b_par_i = 4'h3;
        @(negedge clk);
        ld_i = 1'b0; go_i = 1'b0;
        ma = 4'hA; mb = 4'h3; mc = 1'b0;
        chk(!busy_o && sum_o == 4'hA, "R3 load wins over start", {busy_o, sum_o}, 4'hA);
        @(negedge clk);
        chk(!busy_o && sum_o == 4'hA, "R3 no addition started", {busy_o, sum_o}, 4'hA);

        // R2 load aborts an addition
        @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ld_i = 1'b1; a_par_i = 4'h7; b_par_i = 4'h8;
        @(negedge clk);
        ld_i = 1'b0;
        chk(!busy_o && !done_o && sum_o == 4'h7 && !cout_o, "R2 load aborts",
            {busy_o, done_o, cout_o, sum_o}, 4'h7);
        repeat (W) begin
            @(negedge clk);
            chk(!done_o && sum_o == 4'h7, "R2 R9 no done after abort", {done_o, sum_o}, 4'h7);
        end
        ma = 4'h7; mb = 4'h8; mc = 1'b0;
        do_run(4'h2, 1'b0, "R5 after abort");

        // random mix
        for (int k = 0; k < 60; k++) begin
            if (($urandom % 3) != 0) do_load(W'($urandom), W'($urandom));
            do_run(W'($urandom), ($urandom % 4) == 0, "R5 R6 R8 random add");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule